// File: doc/BRIEF.md
# Low-power halt sequencer

This block sequences the power states of a small processor core. It decides how the core leaves its running state when the core asks to halt, and how it returns to running. When the halt-with-timer option is on, the core's clock and the peripheral clocks stop. The oscillator and one chosen wakeup timer keep running, so the timer can still wake the core. When the option is off, the block enters a deeper halt in which every clock stops.

A reset leaves either halt state through a fixed startup delay, and the core then fetches the reset vector. A wakeup-timer interrupt leaves the timer-kept halt at once, with no delay, and the core fetches the interrupt vector. The block also enforces the watchdog's halt policy, and it clears the core's global interrupt mask whenever a timer-kept halt request is accepted.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: In the running state, a halt_req_i pulse with ah_en_i=1 puts the block into timer-kept halt on the next cycle, provided that in the same cycle rst_req_i is 0, the watchdog reset condition of R6 is absent, and wkup_irq_i and irq_pend_i are both 0. From then on cpu_clk_en_o=0 and per_clk_en_o=0.
- R2: imask_clr_o is a one-cycle pulse in the cycle after every halt request accepted with ah_en_i=1. This includes the case of R3. It is 0 otherwise.
- R3: If wkup_irq_i or irq_pend_i is 1 when a halt request with ah_en_i=1 is accepted, the block stays running. In the next cycle vec_fetch_o pulses with vec_sel_o=1, where 1 selects the interrupt vector.
- R4: In timer-kept halt, osc_en_o=1 and per_clk_en_o=0. Of the tmr_clk_en_o bits, only the bit whose index equals tmr_sel_i is 1.
- R5: Timer-kept halt ends only on wkup_irq_i or rst_req_i. On wkup_irq_i the block is running in the next cycle, with a vec_fetch_o pulse and vec_sel_o=1. irq_pend_i and halt_req_i have no effect in this state.
- R6: A halt request made in the running state while wdg_active_i=1 behaves as follows. If wdg_halt_i=0, wdg_rst_o stays 0. If wdg_halt_i=1, wdg_rst_o pulses for one cycle in the next cycle and the block enters the reset delay, whatever the value of ah_en_i.
- R7: A rst_req_i pulse, or the release of rst_ni, starts the reset delay. During the delay cpu_clk_en_o is 0 for DLY_CYC cycles, osc_en_o=1, and per_clk_en_o and tmr_clk_en_o are 0. After the delay the block is running, vec_fetch_o pulses, and vec_sel_o=0, where 0 selects the reset vector.
- R8: A rst_req_i that arrives during the reset delay restarts the full DLY_CYC-cycle delay.
- R9: A halt request with ah_en_i=0 and no watchdog reset enters full halt. In full halt every output enable is 0, including osc_en_o. Only rst_req_i ends full halt; wkup_irq_i, irq_pend_i and halt_req_i are ignored.
- R10: When rst_req_i and wkup_irq_i arrive in the same cycle, the reset wins: the block enters the reset delay and no interrupt vector fetch follows.
- R11: In the running state with no events, cpu_clk_en_o, per_clk_en_o, osc_en_o and all tmr_clk_en_o bits are 1, and imask_clr_o, wdg_rst_o and vec_fetch_o are 0. vec_sel_o holds the value of the last fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Halt request strobe from the core |
| ah_en_i | input | 1 | Selects timer-kept halt (1) or full halt (0) |
| tmr_sel_i | input | TSW | Index of the wakeup timer kept running |
| wkup_irq_i | input | 1 | Wakeup-timer interrupt |
| irq_pend_i | input | 1 | Any other interrupt pending |
| wdg_active_i | input | 1 | Watchdog is running |
| wdg_halt_i | input | 1 | Watchdog option: halt causes a reset |
| rst_req_i | input | 1 | Synchronous reset request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator keep-alive |
| tmr_clk_en_o | output | NTMR | Per-timer clock enables |
| imask_clr_o | output | 1 | Interrupt mask clear strobe |
| wdg_rst_o | output | 1 | Watchdog reset request strobe |
| vec_fetch_o | output | 1 | Vector fetch strobe |
| vec_sel_o | output | 1 | Vector select: 0 reset, 1 interrupt |

## Verification
The bench builds the block with NTMR=2 and the default DLY_CYC=256. Two timers are enough to show that only the selected enable survives in timer-kept halt, for both values of tmr_sel_i. The full 256-cycle delay is short enough to count exactly, including a restart partway through the delay. A behavioural model follows every cycle, so each reset exit, wakeup and watchdog case is checked against all outputs.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_AHALT = 2'd1,
    PS_FHALT = 2'd2,
    PS_RDLY  = 2'd3
  } pwr_state_e;

  typedef enum logic {
    VEC_RST = 1'b0,
    VEC_IRQ = 1'b1
  } vec_e;
endpackage

// File: rtl/halt_dly_cnt.sv
module halt_dly_cnt #(
  parameter int unsigned DLY_CYC = 256,
  localparam int unsigned CW = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= LOAD_VAL;
    else if (load_i)                cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/halt_pwr_fsm.sv
module halt_pwr_fsm
  import halt_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  logic       ah_en_i,
  input  logic       wkup_irq_i,
  input  logic       irq_pend_i,
  input  logic       wdg_active_i,
  input  logic       wdg_halt_i,
  input  logic       rst_req_i,
  input  logic       cnt_zero_i,
  output pwr_state_e state_o,
  output logic       load_o,
  output logic       imask_clr_o,
  output logic       wdg_rst_o,
  output logic       vec_fetch_o,
  output logic       vec_sel_o
);
  pwr_state_e state_q, state_d;
  vec_e       vsel_q, vsel_d;
  logic       imclr_d, wdg_d, fetch_d;
  logic       imclr_q, wdg_q, fetch_q;

  always_comb begin
    state_d = state_q;
    vsel_d  = vsel_q;
    load_o  = 1'b0;
    imclr_d = 1'b0;
    wdg_d   = 1'b0;
    fetch_d = 1'b0;
    if (rst_req_i) begin
      // reset has priority over every wakeup
      state_d = PS_RDLY;
      load_o  = 1'b1;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (halt_req_i) begin
            if (wdg_active_i && wdg_halt_i) begin
              state_d = PS_RDLY;
              load_o  = 1'b1;
              wdg_d   = 1'b1;
            end else if (!ah_en_i) begin
              state_d = PS_FHALT;
            end else begin
              imclr_d = 1'b1;
              if (wkup_irq_i || irq_pend_i) begin
                // pending interrupt: wake immediately
                fetch_d = 1'b1;
                vsel_d  = VEC_IRQ;
              end else begin
                state_d = PS_AHALT;
              end
            end
          end
        end
        PS_AHALT: begin
          if (wkup_irq_i) begin
            state_d = PS_RUN;
            fetch_d = 1'b1;
            vsel_d  = VEC_IRQ;
          end
        end
        PS_FHALT: ;
        PS_RDLY: begin
          if (cnt_zero_i) begin
            state_d = PS_RUN;
            fetch_d = 1'b1;
            vsel_d  = VEC_RST;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RDLY;
      vsel_q  <= VEC_RST;
      imclr_q <= 1'b0;
      wdg_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      vsel_q  <= vsel_d;
      imclr_q <= imclr_d;
      wdg_q   <= wdg_d;
      fetch_q <= fetch_d;
    end
  end

  assign state_o     = state_q;
  assign imask_clr_o = imclr_q;
  assign wdg_rst_o   = wdg_q;
  assign vec_fetch_o = fetch_q;
  assign vec_sel_o   = vsel_q;
endmodule

// File: rtl/halt_clk_gate.sv
module halt_clk_gate
  import halt_pwr_pkg::*;
#(
  parameter int unsigned NTMR = 2,
  localparam int unsigned TSW = (NTMR > 1) ? $clog2(NTMR) : 1
) (
  input  pwr_state_e        state_i,
  input  logic [TSW-1:0]    tmr_sel_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic [NTMR-1:0]   tmr_clk_en_o
);
  logic run_s, ahalt_s;

  assign run_s        = (state_i == PS_RUN);
  assign ahalt_s      = (state_i == PS_AHALT);
  assign cpu_clk_en_o = run_s;
  assign per_clk_en_o = run_s;
  assign osc_en_o     = (state_i != PS_FHALT);

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    assign tmr_clk_en_o[g] = run_s || (ahalt_s && (tmr_sel_i == TSW'(g)));
  end
endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
  import halt_pwr_pkg::*;
#(
  parameter int unsigned NTMR    = 2,
  parameter int unsigned DLY_CYC = 256,
  localparam int unsigned TSW = (NTMR > 1) ? $clog2(NTMR) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_req_i,
  input  logic            ah_en_i,
  input  logic [TSW-1:0]  tmr_sel_i,
  input  logic            wkup_irq_i,
  input  logic            irq_pend_i,
  input  logic            wdg_active_i,
  input  logic            wdg_halt_i,
  input  logic            rst_req_i,
  output logic            cpu_clk_en_o,
  output logic            per_clk_en_o,
  output logic            osc_en_o,
  output logic [NTMR-1:0] tmr_clk_en_o,
  output logic            imask_clr_o,
  output logic            wdg_rst_o,
  output logic            vec_fetch_o,
  output logic            vec_sel_o
);
  pwr_state_e state;
  logic       load, cnt_zero;

  halt_pwr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_req_i   (halt_req_i),
    .ah_en_i      (ah_en_i),
    .wkup_irq_i   (wkup_irq_i),
    .irq_pend_i   (irq_pend_i),
    .wdg_active_i (wdg_active_i),
    .wdg_halt_i   (wdg_halt_i),
    .rst_req_i    (rst_req_i),
    .cnt_zero_i   (cnt_zero),
    .state_o      (state),
    .load_o       (load),
    .imask_clr_o  (imask_clr_o),
    .wdg_rst_o    (wdg_rst_o),
    .vec_fetch_o  (vec_fetch_o),
    .vec_sel_o    (vec_sel_o)
  );

  halt_dly_cnt #(.DLY_CYC(DLY_CYC)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (state == PS_RDLY),
    .zero_o (cnt_zero)
  );

  halt_clk_gate #(.NTMR(NTMR)) u_gate (
    .state_i      (state),
    .tmr_sel_i    (tmr_sel_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .osc_en_o     (osc_en_o),
    .tmr_clk_en_o (tmr_clk_en_o)
  );
endmodule

// File: rtl/halt_pwr_chk.sv
module halt_pwr_chk
  import halt_pwr_pkg::*;
#(
  parameter int unsigned NTMR = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input pwr_state_e      state,
  input logic            halt_req_i,
  input logic            ah_en_i,
  input logic            wkup_irq_i,
  input logic            irq_pend_i,
  input logic            wdg_active_i,
  input logic            wdg_halt_i,
  input logic            rst_req_i,
  input logic            cpu_clk_en_o,
  input logic            per_clk_en_o,
  input logic            osc_en_o,
  input logic [NTMR-1:0] tmr_clk_en_o,
  input logic            imask_clr_o,
  input logic            wdg_rst_o,
  input logic            vec_fetch_o,
  input logic            vec_sel_o
);
  logic ah_acc;
  assign ah_acc = (state == PS_RUN) && halt_req_i && ah_en_i && !rst_req_i
                  && !(wdg_active_i && wdg_halt_i);

  // R1
  ah_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ah_acc && !wkup_irq_i && !irq_pend_i |=> !cpu_clk_en_o && !per_clk_en_o);

  // R2
  imask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ah_acc |=> imask_clr_o);

  // R3
  pend_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ah_acc && (wkup_irq_i || irq_pend_i) |=> cpu_clk_en_o && vec_fetch_o && vec_sel_o);

  // R4
  ah_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == PS_AHALT |-> osc_en_o && !per_clk_en_o && ($countones(tmr_clk_en_o) == 1));

  // R5
  ah_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == PS_AHALT && !wkup_irq_i && !rst_req_i |=> state == PS_AHALT);

  // R6
  wdg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_i && ah_en_i && !wdg_halt_i |=> !wdg_rst_o);

  // R7
  fetch_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> vec_fetch_o);

  // R9
  fh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == PS_FHALT && !rst_req_i |=> state == PS_FHALT && !osc_en_o);

  // R10
  rst_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !cpu_clk_en_o && !vec_fetch_o);
endmodule

bind halt_pwr_ctrl halt_pwr_chk #(.NTMR(NTMR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state        (state),
  .halt_req_i   (halt_req_i),
  .ah_en_i      (ah_en_i),
  .wkup_irq_i   (wkup_irq_i),
  .irq_pend_i   (irq_pend_i),
  .wdg_active_i (wdg_active_i),
  .wdg_halt_i   (wdg_halt_i),
  .rst_req_i    (rst_req_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .osc_en_o     (osc_en_o),
  .tmr_clk_en_o (tmr_clk_en_o),
  .imask_clr_o  (imask_clr_o),
  .wdg_rst_o    (wdg_rst_o),
  .vec_fetch_o  (vec_fetch_o),
  .vec_sel_o    (vec_sel_o)
);

// File: tb/halt_pwr_ctrl_tb.sv
module halt_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam int NTMR = 2;
  localparam int DLY = 256;
  localparam int TSW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, ah_en = 1, wkup = 0, pend = 0, wdg_act = 0, wdg_halt = 0, rst_req = 0;
  logic [TSW-1:0] tmr_sel = '0;
  logic cpu_en, per_en, osc_en, imclr, wdg_rst, fetch, vsel;
  logic [NTMR-1:0] tmr_en;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_pwr_ctrl #(.NTMR(NTMR), .DLY_CYC(DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .ah_en_i(ah_en),
    .tmr_sel_i(tmr_sel), .wkup_irq_i(wkup), .irq_pend_i(pend),
    .wdg_active_i(wdg_act), .wdg_halt_i(wdg_halt), .rst_req_i(rst_req),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .tmr_clk_en_o(tmr_en), .imask_clr_o(imclr), .wdg_rst_o(wdg_rst),
    .vec_fetch_o(fetch), .vec_sel_o(vsel)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: 0 run, 1 timer halt, 2 full halt, 3 delay
  int m_st, m_left;
  bit m_fetch, m_imclr, m_wdg, m_vsel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 3; m_left = DLY; m_fetch = 0; m_imclr = 0; m_wdg = 0; m_vsel = 0;
    end else begin
      m_fetch = 0; m_imclr = 0; m_wdg = 0;
      if (rst_req) begin
        m_st = 3; m_left = DLY;
      end else if (m_st == 0 && halt_req) begin
        if (wdg_act && wdg_halt) begin
          m_st = 3; m_left = DLY; m_wdg = 1;
        end else if (!ah_en) m_st = 2;
        else begin
          m_imclr = 1;
          if (wkup || pend) begin m_fetch = 1; m_vsel = 1; end
          else m_st = 1;
        end
      end else if (m_st == 1 && wkup) begin
        m_st = 0; m_fetch = 1; m_vsel = 1;
      end else if (m_st == 3) begin
        m_left--;
        if (m_left == 0) begin m_st = 0; m_fetch = 1; m_vsel = 0; end
      end
    end
  end

  always @(negedge clk) begin
    #(Q);
    if (cmp_en && rst_n) begin
      logic [NTMR-1:0] e_tmr;
      e_tmr = '0;
      if (m_st == 0) e_tmr = '1;
      else if (m_st == 1) e_tmr[tmr_sel] = 1'b1;
      chk("R7",  "cpu_clk_en", int'(cpu_en), int'(m_st == 0));
      chk("R4",  "per_clk_en", int'(per_en), int'(m_st == 0));
      chk("R9",  "osc_en",     int'(osc_en), int'(m_st != 2));
      chk("R4",  "tmr_clk_en", int'(tmr_en), int'(e_tmr));
      chk("R2",  "imask_clr",  int'(imclr),  int'(m_imclr));
      chk("R6",  "wdg_rst",    int'(wdg_rst), int'(m_wdg));
      chk("R5",  "vec_fetch",  int'(fetch),  int'(m_fetch));
      chk("R11", "vec_sel",    int'(vsel),   int'(m_vsel));
    end
  end

  task automatic wait_run();
    while (!cpu_en) begin @(negedge clk); #(Q); end
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0; #(Q);
  endtask

  task automatic pulse_rst(output int n);
    @(negedge clk); rst_req = 1;
    @(negedge clk); rst_req = 0; #(Q);
    n = 0;
    while (!cpu_en) begin n++; @(negedge clk); #(Q); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #(Q);
    // reset state: delay state
    chk("R7", "reset cpu_clk_en", int'(cpu_en), 0);
    chk("R7", "reset osc_en", int'(osc_en), 1);
    chk("R7", "reset tmr_clk_en", int'(tmr_en), 0);
    @(negedge clk); rst_n = 1; cmp_en = 1;
    #(Q); wait_run();
    chk("R7", "reset exit fetch", int'(fetch), 1);
    chk("R7", "reset exit vec_sel", int'(vsel), 0);
    repeat (3) @(negedge clk);
    #(Q);
    chk("R11", "run tmr_clk_en", int'(tmr_en), 3);
    chk("R11", "run strobes", int'({imclr, wdg_rst, fetch}), 0);

    // R1 R4 R5: timer-kept halt, timer 0
    tmr_sel = 0;
    pulse_halt();
    chk("R1", "halt cpu_clk_en", int'(cpu_en), 0);
    chk("R2", "imask_clr", int'(imclr), 1);
    chk("R4", "tmr0 only", int'(tmr_en), 1);
    @(negedge clk); pend = 1; halt_req = 1;
    @(negedge clk); halt_req = 0;
    repeat (3) @(negedge clk);
    pend = 0; #(Q);
    chk("R5", "pend ignored", int'(cpu_en), 0);
    @(negedge clk); wkup = 1;
    @(negedge clk); wkup = 0; #(Q);
    chk("R5", "wake cpu", int'(cpu_en), 1);
    chk("R5", "wake vec_sel", int'(vsel), 1);

    // R4: timer 1
    @(negedge clk); tmr_sel = 1;
    pulse_halt();
    chk("R4", "tmr1 only", int'(tmr_en), 2);
    @(negedge clk); wkup = 1;
    @(negedge clk); wkup = 0; #(Q);
    wait_run();

    // R3: pending at request
    @(negedge clk); pend = 1;
    pulse_halt();
    pend = 0;
    chk("R3", "pend stays run", int'(cpu_en), 1);
    chk("R3", "pend fetch", int'(fetch), 1);
    chk("R2", "pend imask_clr", int'(imclr), 1);
    @(negedge clk); wkup = 1;
    pulse_halt();
    wkup = 0;
    chk("R3", "wkup stays run", int'(cpu_en), 1);

    // R6: watchdog active, no halt reset option
    @(negedge clk); wdg_act = 1; wdg_halt = 0;
    pulse_halt();
    chk("R6", "no wdg reset", int'(wdg_rst), 0);
    chk("R1", "halted with wdg", int'(cpu_en), 0);
    @(negedge clk); wkup = 1;
    @(negedge clk); wkup = 0; #(Q);

    // R6: halt reset option set
    @(negedge clk); wdg_halt = 1;
    pulse_halt();
    chk("R6", "wdg reset pulse", int'(wdg_rst), 1);
    chk("R6", "wdg enters delay", int'(cpu_en), 0);
    wait_run();
    chk("R6", "wdg exit vec_sel", int'(vsel), 0);
    @(negedge clk); wdg_act = 0; wdg_halt = 0;

    // R9: full halt
    @(negedge clk); ah_en = 0;
    pulse_halt();
    chk("R9", "full halt osc", int'(osc_en), 0);
    @(negedge clk); wkup = 1; pend = 1; halt_req = 1;
    @(negedge clk); wkup = 0; pend = 0; halt_req = 0; #(Q);
    chk("R9", "full halt ignores wake", int'(cpu_en), 0);
    chk("R9", "full halt tmr", int'(tmr_en), 0);
    ah_en = 1;
    pulse_rst(n);
    chk("R7", "delay length", n, DLY);
    chk("R7", "delay exit fetch", int'(fetch), 1);
    chk("R7", "delay exit vec_sel", int'(vsel), 0);

    // R10: reset and wakeup together
    pulse_halt();
    @(negedge clk); rst_req = 1; wkup = 1;
    @(negedge clk); rst_req = 0; wkup = 0; #(Q);
    chk("R10", "reset wins cpu", int'(cpu_en), 0);
    chk("R10", "reset wins no fetch", int'(fetch), 0);
    wait_run();
    chk("R10", "reset wins vec_sel", int'(vsel), 0);

    // R8: restart during delay
    @(negedge clk); rst_req = 1;
    @(negedge clk); rst_req = 0;
    repeat (100) @(negedge clk);
    #(Q);
    chk("R8", "still in delay", int'(cpu_en), 0);
    pulse_rst(n);
    chk("R8", "restarted delay length", n, DLY);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule